// File: doc/BRIEF.md
# GPIO edge-detect interrupt unit

This unit watches a bank of general-purpose input pins and records edges on them. Each pin has two enable bits, one for rising edges and one for falling edges. When an enabled edge is seen on a pin, that pin's bit in a sticky pending register is set. Setting both enables makes the pin record either edge. Software clears pending bits by writing ones to them, so writing back a value just read clears exactly what was seen.

The lower pins (0 to 10 by default) each drive their own interrupt line, which mirrors the pin's pending bit. The remaining upper pins share one combined interrupt line, which is the OR of their pending bits. A per-pin wake mask selects the pending bits that raise a wake request. Pin inputs are treated as asynchronous and pass through a two-flop synchronizer before edge detection. All registers sit behind a simple single-cycle register port with a write strobe and a combinational read.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the rising-enable, falling-enable, wake-mask and pending registers all read 0, every interrupt line is low and the wake request is low.
- R2: With a pin's rising enable set, a 0-to-1 change on that pin sets its pending bit. The bit first reads 1 after the third rising clock edge that follows the pin change: two synchronizer flops, then the edge-compare register.
- R3: With a pin's falling enable set, a 1-to-0 change on that pin sets its pending bit, with the same latency as R2.
- R4: With both enables set, a pin records an edge in either direction.
- R5: An edge whose direction is not enabled for that pin leaves the pending bit unchanged.
- R6: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. Pending bits change in no other way except by being set through R2 to R4.
- R7: If a new edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: Clearing an enable bit does not clear a pending bit that is already set.
- R9: Interrupt line `irq_low_o[i]` equals pending bit i for i from 0 to 10.
- R10: `irq_high_o` is 1 exactly when any pending bit from 11 to 27 is 1.
- R11: `wake_req_o` is 1 exactly when some pending bit is 1 and its wake-mask bit is also 1.
- R12: The register map is: address 0 is rising enable, address 1 is falling enable, address 2 is wake mask, and address 3 is pending. Bit n of each register belongs to pin n. The first three registers read back what was written. Addresses 4 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 28 | Asynchronous pin levels |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 28 | Write data |
| reg_rdata | output | 28 | Read data for `reg_addr`, combinational |
| irq_low_o | output | 11 | Per-pin interrupt lines for pins 0 to 10 |
| irq_high_o | output | 1 | Shared interrupt line for pins 11 to 27 |
| wake_req_o | output | 1 | Wake request |

## Verification
The hardest case to reach is the collision of R7. In that case a clearing write must land in the same clock cycle in which the edge detector raises a set for a bit that is already pending. The bench gets there by counting the synchronizer latency from the pin change. It drives the pin on a falling clock edge, lets two rising edges pass, and then issues the clearing write so that it is captured on the third rising edge, the same one on which the new set lands. A clear-wins design would show the bit as 0 at the next read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_RISE = 3'd0,
    REG_FALL = 3'd1,
    REG_WAKE = 3'd2,
    REG_STAT = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_find.sv
module gpio_edge_find #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rise_en_o,
  output logic [W-1:0]          fall_en_o,
  output logic [W-1:0]          wake_en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      wake_en_o <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_RISE: rise_en_o <= wdata;
        REG_FALL: fall_en_o <= wdata;
        REG_WAKE: wake_en_o <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] set_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] clr_vec;

  assign set_o   = (rise_i & rise_en_i) | (fall_i & fall_en_i);
  assign clr_vec = clr_en_i ? clr_mask_i : '0;

  // The set term is applied after the clear, so a same-cycle set is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_vec) | set_o;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_DIRECT  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  output logic [NUM_PINS-1:0]   reg_rdata,
  output logic [NUM_DIRECT-1:0] irq_low_o,
  output logic                  irq_high_o,
  output logic                  wake_req_o
);
  localparam int NUM_SHARED = NUM_PINS - NUM_DIRECT;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] rise_evt, fall_evt;
  logic [NUM_PINS-1:0] rise_en, fall_en, wake_en;
  logic [NUM_PINS-1:0] set_vec, status_q;
  logic                stat_wr;

  gpio_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  gpio_edge_find #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pin_sync),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  gpio_cfg_regs #(.W(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .wake_en_o(wake_en)
  );

  assign stat_wr = reg_wr_en && (reg_addr == REG_STAT);

  gpio_evt_status #(.W(NUM_PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_evt), .fall_i(fall_evt),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_en_i(stat_wr),
    .clr_mask_i(reg_wdata), .set_o(set_vec), .status_o(status_q)
  );

  always_comb begin
    case (reg_addr)
      REG_RISE: reg_rdata = rise_en;
      REG_FALL: reg_rdata = fall_en;
      REG_WAKE: reg_rdata = wake_en;
      REG_STAT: reg_rdata = status_q;
      default:  reg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
    assign irq_low_o[i] = status_q[i];
  end

  logic [NUM_SHARED-1:0] shared_bits;
  assign shared_bits = status_q[NUM_PINS-1:NUM_DIRECT];
  assign irq_high_o  = |shared_bits;
  assign wake_req_o  = |(status_q & wake_en);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [NUM_PINS-1:0]   reg_wdata,
  input logic [NUM_PINS-1:0]   status_q,
  input logic [NUM_PINS-1:0]   set_vec,
  input logic [NUM_PINS-1:0]   rise_en,
  input logic [NUM_PINS-1:0]   fall_en,
  input logic [NUM_PINS-1:0]   wake_en,
  input logic [NUM_DIRECT-1:0] irq_low_o,
  input logic                  irq_high_o,
  input logic                  wake_req_o
);
  logic stat_wr;
  assign stat_wr = reg_wr_en && (reg_addr == REG_STAT);

  a_r9_direct_lines: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low_o == status_q[NUM_DIRECT-1:0]);

  a_r10_shared_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_high_o == (status_q[NUM_PINS-1:NUM_DIRECT] != '0));

  a_r11_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o == ((status_q & wake_en) != '0));

  a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> (($past(status_q) & ~status_q) == '0));

  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_wr) |-> (($past(status_q) & ~status_q & ~$past(reg_wdata)) == '0));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_vec) & ~status_q) == '0);

  a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~$past(status_q) & ~($past(rise_en) | $past(fall_en))) == '0);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status_q(status_q), .set_vec(set_vec),
  .rise_en(rise_en), .fall_en(fall_en), .wake_en(wake_en),
  .irq_low_o(irq_low_o), .irq_high_o(irq_high_o), .wake_req_o(wake_req_o)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  localparam int NP = 28;
  localparam int ND = 11;

  typedef struct packed {
    logic [NP-1:0] pins;
    logic [NP-1:0] exp;
  } vec_t;

  // rise enable = pins 0,1,11 ; fall enable = pins 1,2,27 (pending reg at address 3)
  localparam vec_t VECS [6] = '{
    '{pins: 28'h0000001, exp: 28'h0000001},  // R2 pin0 rises
    '{pins: 28'h0000007, exp: 28'h0000002},  // R2/R4 pin1 rises, R5 pin2 rise ignored
    '{pins: 28'h8000800, exp: 28'h0000806},  // R3/R4/R5 mixed
    '{pins: 28'h0000000, exp: 28'h8000000},  // R3 pin27 falls, R5 pin11 fall ignored
    '{pins: 28'hFFFFFFF, exp: 28'h0000803},  // R2 all rise
    '{pins: 28'h0000000, exp: 28'h8000006}   // R3 all fall
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic          reg_wr_en = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [NP-1:0] reg_wdata = '0;
  logic [NP-1:0] reg_rdata;
  logic [ND-1:0] irq_low_o;
  logic          irq_high_o;
  logic          wake_req_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_low_o(irq_low_o), .irq_high_o(irq_high_o), .wake_req_o(wake_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_i = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      chk("R1 reg after reset", 32'(d), 32'h0);
    end
    chk("R1 irq lines", {20'h0, irq_low_o, irq_high_o}, 32'h0);
    chk("R1 wake", 32'(wake_req_o), 32'h0);

    // R12 register map
    wr(3'd0, 28'h0000803);
    wr(3'd1, 28'h8000006);
    wr(3'd2, 28'h0000000);
    wr(3'd5, 28'hFFFFFFF);
    rd(3'd0, d); chk("R12 rise readback", 32'(d), 32'h0000803);
    rd(3'd1, d); chk("R12 fall readback", 32'(d), 32'h8000006);
    rd(3'd2, d); chk("R12 wake readback", 32'(d), 32'h0);
    rd(3'd5, d); chk("R12 unused addr", 32'(d), 32'h0);

    // table walk: R2 R3 R4 R5 R9 R10 R6
    foreach (VECS[i]) begin
      drive_pins(VECS[i].pins);
      rd(3'd3, d);
      chk("R2/R3/R4/R5 pending", 32'(d), 32'(VECS[i].exp));
      chk("R9 direct lines", 32'(irq_low_o), 32'(VECS[i].exp[ND-1:0]));
      chk("R10 shared line", 32'(irq_high_o), 32'(|VECS[i].exp[NP-1:ND]));
      wr(3'd3, d);
      rd(3'd3, d);
      chk("R6 write-back clears", 32'(d), 32'h0);
    end

    // R2 latency: not yet visible after two rising edges
    @(negedge clk); pin_i = 28'h0000001;
    repeat (2) @(negedge clk);
    rd(3'd3, d); chk("R2 not before third edge", 32'(d), 32'h0);
    @(negedge clk);
    rd(3'd3, d); chk("R2 set on third edge", 32'(d), 32'h0000001);

    // R6 partial clear: bits 0 and 1 pending, clear only bit 0
    drive_pins(28'h0000003);
    rd(3'd3, d); chk("R6 two pending", 32'(d), 32'h0000003);
    wr(3'd3, 28'h0000001);
    rd(3'd3, d); chk("R6 zeros keep bits", 32'(d), 32'h0000002);
    wr(3'd3, 28'hFFFFFFF);

    // R11 wake: mask pin 2 only
    wr(3'd2, 28'h0000004);
    drive_pins(28'h0000000);  // pin1 falls -> pending, pin0 fall not enabled
    rd(3'd3, d); chk("R11 pending before", 32'(d), 32'h0000002);
    chk("R11 unmasked pending no wake", 32'(wake_req_o), 32'h0);
    drive_pins(28'h0000004);
    drive_pins(28'h0000000);  // pin2 falls
    chk("R11 masked pending wakes", 32'(wake_req_o), 32'h1);
    wr(3'd2, 28'h0000000);
    chk("R11 mask cleared", 32'(wake_req_o), 32'h0);
    wr(3'd3, 28'hFFFFFFF);

    // R8 clearing an enable keeps pending
    wr(3'd0, 28'h0000810);
    drive_pins(28'h0000010);
    wr(3'd0, 28'h0000000);
    rd(3'd3, d); chk("R8 pending kept", 32'(d), 32'h0000010);
    chk("R9 pin4 line", 32'(irq_low_o), 32'h010);
    wr(3'd3, 28'hFFFFFFF);

    // R7 same-cycle set and clear on pin 5 (both edges enabled)
    wr(3'd0, 28'h0000020);
    wr(3'd1, 28'h0000020);
    drive_pins(28'h0000020);
    rd(3'd3, d); chk("R7 setup pending", 32'(d), 32'h0000020);
    @(negedge clk); pin_i = 28'h0000000;
    @(negedge clk);
    wr(3'd3, 28'h0000020);   // captured on the same edge as the new set
    rd(3'd3, d); chk("R7 set wins", 32'(d), 32'h0000020);
    wr(3'd3, 28'h0000020);
    rd(3'd3, d); chk("R7 later clear works", 32'(d), 32'h0);

    // R10 a single high pin
    wr(3'd0, 28'h4000000);
    drive_pins(28'h4000000);
    chk("R10 pin26 shared line", 32'(irq_high_o), 32'h1);
    chk("R9 low lines quiet", 32'(irq_low_o), 32'h0);
    wr(3'd3, 28'h4000000);
    chk("R10 shared line cleared", 32'(irq_high_o), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule